// File: doc/BRIEF.md
# Oversampling Serial Receiver with Standby

This block receives asynchronous serial characters using a sample tick that runs at sixteen times the bit rate. A falling line edge after a high sample starts a frame. The middle of the start bit is checked to confirm it. Each data bit and the stop bit are then decided by a majority of three samples taken near the centre of the bit. Characters carry eight or nine data bits, sent least significant bit first.

Each completed frame loads the character into the data output and updates the framing and noise indications. In normal operation a completed frame also sets a ready flag, which a one-cycle read strobe clears. A standby control lets a receiver skip traffic meant for other nodes. While standby is set, characters are still loaded into the data output, but the ready flag is not set and the interrupt request is held low. Only the standby input itself ends standby.

Top module: `ovs_serial_rx`

## Requirements
- R1: In idle, a frame starts on the first sample tick that sees the line low when the previous tick saw it high. That tick is counted as sample 1 of the start bit. If the majority of start-bit samples 8, 9 and 10 is high, the receiver returns to idle and no output changes.
- R2: Every bit period lasts 16 sample ticks. A bit's value is the majority of its samples 8, 9 and 10. A sample outside those three positions has no effect on the value or on the noise flag.
- R3: With `nine_bit_i` low, a frame is start + 8 data + stop. The character appears on `data_o[7:0]` in LSB-first order, with `data_o[8]` = 0. The frame completes on the 154th sample tick, counting the first low tick as the 1st, and outputs are updated at that clock edge.
- R4: With `nine_bit_i` high, a frame carries 9 data bits, and the ninth received bit appears on `data_o[8]`. Completion falls on the 170th sample tick.
- R5: Frames whose transmitter bit period is about 3% shorter or longer than 16 ticks are received without error in both character sizes.
- R6: If the three samples of any bit in a frame (start, data or stop) disagree, `noise_o` is 1 after that frame completes. Otherwise it is 0.
- R7: If the stop bit's majority is 0, `frame_err_o` is 1 after that frame completes, and the character is still loaded. Otherwise it is 0.
- R8: A frame that completes while `standby_i` is low sets `ready_o`. A `rd_strobe_i` pulse clears it on the next clock. When both fall in the same cycle, `ready_o` stays set.
- R9: A frame that completes while `standby_i` is high loads `data_o`, `frame_err_o` and `noise_o`, but does not set `ready_o`.
- R10: `irq_o` is 1 exactly when `ready_o` is 1 and `standby_i` is 0.
- R11: After reset, `data_o`, `ready_o`, `irq_o`, `frame_err_o` and `noise_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Sample tick, one clock wide, at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| standby_i | input | 1 | 1 puts the receiver in standby |
| rd_strobe_i | input | 1 | One-cycle read acknowledge that clears the ready flag |
| data_o | output | 9 | Last received character, ninth bit on top |
| ready_o | output | 1 | A character has arrived and has not been read |
| irq_o | output | 1 | Interrupt request |
| frame_err_o | output | 1 | Last frame's stop bit was sampled low |
| noise_o | output | 1 | Last frame had a split three-sample vote |

## Verification
The read strobe and the completion of a frame can land on the same clock, and the ready flag must then stay set. The bench provokes this by driving the strobe exactly on the 154th sample tick of a frame that follows an unread one. It judges that `ready_o` is still 1 afterwards, and that a later lone strobe clears it. Standby toggling against an already-set flag is checked the same way, through `irq_o`.

// File: rtl/ovs_rx_pkg.sv
// Package: shared types for the oversampling receiver.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ovs_rx_pkg;
    // Frame sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } rx_phase_t;
endpackage

// File: rtl/ovs_rx_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high; stages reset to 1 so no false edge appears.
module ovs_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Each stage samples the previous one (stage 0 samples the line)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q[g] <= 1'b1;
            end else if (g == 0) begin
                chain_q[g] <= d_i;
            end else begin
                chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ovs_rx_vote.sv
// Module: three-sample majority decision with disagreement detection.
// Purely combinational; assumes the three samples belong to one bit.
module ovs_rx_vote (
    input  logic [2:0] smp_i,
    output logic       bit_o,
    output logic       split_o
);
    // Majority value and whether the samples were not unanimous
    always_comb begin
        bit_o   = (smp_i[0] & smp_i[1]) | (smp_i[0] & smp_i[2]) | (smp_i[1] & smp_i[2]);
        split_o = (smp_i != 3'b000) && (smp_i != 3'b111);
    end
endmodule

// File: rtl/ovs_rx_frame.sv
// Module: frame sequencer. It detects the start edge, counts sample ticks
// within each bit, collects the mid-bit samples and shifts in data LSB first.
// Assumes tick_i is one clock wide and nine_i is stable during a frame.
module ovs_rx_frame
    import ovs_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int MID = 8,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_i,
    input  logic          nine_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          ferr_o,
    output logic          noise_o
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DW + 1);
    localparam int RT_A = MID - 1;
    localparam int RT_B = MID;
    localparam int RT_C = MID + 1;

    rx_phase_t     phase_q;
    logic [CW-1:0] rt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] shift_q;
    logic [1:0]    smp_q;
    logic          noise_q;
    logic          prev_q;
    logic          v_bit;
    logic          v_split;
    logic [BW-1:0] last_bit;

    ovs_rx_vote u_vote (
        .smp_i   ({smp_q[1], smp_q[0], line_i}),
        .bit_o   (v_bit),
        .split_o (v_split)
    );

    // Index of the final data bit for the selected character size
    assign last_bit = nine_i ? BW'(DW - 1) : BW'(DW - 2);

    // Sequencer: advances only on sample ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            rt_q    <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            smp_q   <= '0;
            noise_q <= 1'b0;
            prev_q  <= 1'b0;
        end else if (tick_i) begin
            prev_q <= line_i;
            if (phase_q == PH_IDLE) begin
                if (prev_q && !line_i) begin
                    phase_q <= PH_START;
                    rt_q    <= CW'(1);
                    bit_q   <= '0;
                    noise_q <= 1'b0;
                end
            end else begin
                rt_q <= (rt_q == CW'(OVS - 1)) ? '0 : rt_q + CW'(1);
                if (rt_q == CW'(RT_A)) smp_q[0] <= line_i;
                if (rt_q == CW'(RT_B)) smp_q[1] <= line_i;
                if (rt_q == CW'(RT_C)) begin
                    noise_q <= noise_q | v_split;
                    case (phase_q)
                        PH_START: if (v_bit) phase_q <= PH_IDLE;
                        PH_DATA:  shift_q <= {v_bit, shift_q[DW-1:1]};
                        PH_STOP:  phase_q <= PH_IDLE;
                        default:  ;
                    endcase
                end
                if (rt_q == CW'(OVS - 1)) begin
                    if (phase_q == PH_START) begin
                        phase_q <= PH_DATA;
                    end else if (phase_q == PH_DATA) begin
                        if (bit_q == last_bit) phase_q <= PH_STOP;
                        else                   bit_q   <= bit_q + BW'(1);
                    end
                end
            end
        end
    end

    // Frame results, valid in the completion cycle
    always_comb begin
        done_o  = tick_i && (phase_q == PH_STOP) && (rt_q == CW'(RT_C));
        data_o  = nine_i ? shift_q : {1'b0, shift_q[DW-1:1]};
        ferr_o  = !v_bit;
        noise_o = noise_q | v_split;
    end

    // R1: leaving idle must follow a high-then-low pair of line samples
    assert_start_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && $past(phase_q) == PH_IDLE) |-> ($past(prev_q) && !$past(line_i)));

    // R3: the stop phase is reached only after the last data bit
    assert_stop_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STOP) |-> (bit_q == last_bit));

    // R4: the data bit counter stays inside the widest character
    assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BW'(DW - 1));
endmodule

// File: rtl/ovs_serial_rx.sv
// Module: top of the oversampling serial receiver with standby.
// It holds the character, the status flags and the ready/interrupt logic.
// Assumes tick_i comes from an external rate generator at 16x the bit rate.
module ovs_serial_rx #(
    parameter int OVS      = 16,
    parameter int MID      = 8,
    parameter int DW       = 9,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rxd_i,
    input  logic          nine_bit_i,
    input  logic          standby_i,
    input  logic          rd_strobe_i,
    output logic [DW-1:0] data_o,
    output logic          ready_o,
    output logic          irq_o,
    output logic          frame_err_o,
    output logic          noise_o
);
    logic          line_s;
    logic          frame_done;
    logic [DW-1:0] frame_data;
    logic          frame_ferr;
    logic          frame_noise;
    logic [DW-1:0] data_q;
    logic          ready_q;
    logic          ferr_q;
    logic          noise_q;

    ovs_rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (line_s)
    );

    ovs_rx_frame #(.OVS(OVS), .MID(MID), .DW(DW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .line_i  (line_s),
        .nine_i  (nine_bit_i),
        .done_o  (frame_done),
        .data_o  (frame_data),
        .ferr_o  (frame_ferr),
        .noise_o (frame_noise)
    );

    // Character and status capture; loaded on every completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ferr_q  <= 1'b0;
            noise_q <= 1'b0;
        end else if (frame_done) begin
            data_q  <= frame_data;
            ferr_q  <= frame_ferr;
            noise_q <= frame_noise;
        end
    end

    // Ready flag: set by a frame outside standby, which wins over a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (frame_done && !standby_i) begin
            ready_q <= 1'b1;
        end else if (rd_strobe_i) begin
            ready_q <= 1'b0;
        end
    end

    assign data_o      = data_q;
    assign ready_o     = ready_q;
    assign frame_err_o = ferr_q;
    assign noise_o     = noise_q;
    assign irq_o       = ready_q && !standby_i;

    // R9: the character only changes after a completed frame
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(data_o));

    // R8: a frame completed outside standby leaves the flag set
    assert_ready_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !standby_i) |=> ready_o);

    // R8: a lone read strobe clears the flag
    assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && !frame_done) |=> !ready_o);

    // R9: the flag never rises from a frame taken in standby
    assert_standby_noset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(!standby_i));
endmodule

// File: tb/ovs_serial_rx_bench.sv
// Bench: directed corner cases plus seeded random frames for ovs_serial_rx.
module ovs_serial_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       nine = 1'b0;
    logic       stby = 1'b0;
    logic       rd = 1'b0;
    logic [8:0] data;
    logic       ready, irq, ferr, noise;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic exp_ready = 1'b0;
    logic rdy_before, rdy_at;

    always #10 clk = ~clk;

    ovs_serial_rx u_ovs_serial_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .rxd_i       (rxd),
        .nine_bit_i  (nine),
        .standby_i   (stby),
        .rd_strobe_i (rd),
        .data_o      (data),
        .ready_o     (ready),
        .irq_o       (irq),
        .frame_err_o (ferr),
        .noise_o     (noise)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One sample tick that sees 'line'; the line settles through the synchronizer first
    task automatic tk(input logic line, input logic strb);
        @(negedge clk); rxd = line;
        repeat (3) @(negedge clk);
        tick = 1'b1; rd = strb;
        @(negedge clk);
        tick = 1'b0; rd = 1'b0;
    endtask

    // Line level at tick i of a frame whose transmit bit lasts p/16 ticks
    function automatic logic line_at(int i, logic [8:0] d, bit nb9, int p, logic stop_v);
        int nb = nb9 ? 9 : 8;
        int b  = (16 * i) / p;
        if (b == 0) return 1'b0;
        if (b <= nb) return d[b-1];
        if (b == nb + 1) return stop_v;
        return 1'b1;
    endfunction

    function automatic logic [8:0] exp_data(logic [8:0] d, bit nb9);
        return nb9 ? d : {1'b0, d[7:0]};
    endfunction

    task automatic send(input logic [8:0] d, input bit nb9, input int p, input logic stop_v,
                        input int flip_at, input bit strb_done);
        int nb = nb9 ? 9 : 8;
        int done_i = 16 * (nb + 1) + 9;
        nine = nb9;
        tk(1'b1, 1'b0); tk(1'b1, 1'b0);
        for (int i = 0; i < 16 * (nb + 2) + 6; i++) begin
            logic l = line_at(i, d, nb9, p, stop_v);
            if (i == flip_at) l = ~l;
            tk(l, strb_done && (i == done_i));
            if (i == done_i - 1) rdy_before = ready;
            if (i == done_i) rdy_at = ready;
        end
        if (!stby) exp_ready = 1'b1;
        else if (strb_done) exp_ready = 1'b0;
    endtask

    task automatic verify(input string req, input logic [8:0] d, input bit nb9,
                          input logic fe, input logic nz);
        check({req, " data"}, 32'(data), 32'(exp_data(d, nb9)));
        check({req, " ready"}, 32'(ready), 32'(exp_ready));
        check({req, " R10 irq"}, 32'(irq), 32'(exp_ready & !stby));
        check({req, " R7 frame_err"}, 32'(ferr), 32'(fe));
        check({req, " R6 noise"}, 32'(noise), 32'(nz));
    endtask

    task automatic do_read();
        tk(1'b1, 1'b1);
        exp_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] hold;
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 data", 32'(data), 0);
        check("R11 ready", 32'(ready), 0);
        check("R11 irq", 32'(irq), 0);
        check("R11 flags", 32'({ferr, noise}), 0);
        rst_n = 1'b1;
        repeat (2) tk(1'b1, 1'b0);

        // R3: nominal 8-bit frame, completion on the 154th tick
        send(9'h0A5, 0, 256, 1'b1, -1, 0);
        verify("R3", 9'h0A5, 0, 1'b0, 1'b0);
        check("R3 not ready before tick 154", 32'(rdy_before), 0);
        check("R3 ready at tick 154", 32'(rdy_at), 1);

        // R8: lone read strobe clears ready
        do_read();
        check("R8 cleared by strobe", 32'(ready), 0);

        // R4: nominal 9-bit frame, completion on the 170th tick
        send(9'h1C3, 1, 256, 1'b1, -1, 0);
        verify("R4", 9'h1C3, 1, 1'b0, 1'b0);
        check("R4 not ready before tick 170", 32'(rdy_before), 0);
        check("R4 ready at tick 170", 32'(rdy_at), 1);
        do_read();

        // R5: fast and slow transmitters
        send(9'h03C, 0, 248, 1'b1, -1, 0); verify("R5 fast8", 9'h03C, 0, 0, 0); do_read();
        send(9'h155, 1, 248, 1'b1, -1, 0); verify("R5 fast9", 9'h155, 1, 0, 0); do_read();
        send(9'h0E1, 0, 264, 1'b1, -1, 0); verify("R5 slow8", 9'h0E1, 0, 0, 0); do_read();
        send(9'h0AA, 1, 264, 1'b1, -1, 0); verify("R5 slow9", 9'h0AA, 1, 0, 0); do_read();

        // R6/R2: one flipped sample at RT9 of data bit 3 gives noise, not a wrong bit
        send(9'h05A, 0, 256, 1'b1, 16 * 4 + 8, 0); verify("R6 split vote", 9'h05A, 0, 0, 1); do_read();
        // R2: flips at RT7 and RT11 sit outside the sample window
        send(9'h05A, 0, 256, 1'b1, 16 * 4 + 6, 0); verify("R2 rt7", 9'h05A, 0, 0, 0); do_read();
        send(9'h05A, 0, 256, 1'b1, 16 * 4 + 10, 0); verify("R2 rt11", 9'h05A, 0, 0, 0); do_read();

        // R7: low stop bit flags framing error and still loads data
        send(9'h13F, 1, 256, 1'b0, -1, 0); verify("R7 framing", 9'h13F, 1, 1, 0); do_read();

        // R1: a short low glitch is not a start
        hold = data;
        tk(1'b1, 1'b0);
        repeat (4) tk(1'b0, 1'b0);
        repeat (40) tk(1'b1, 1'b0);
        check("R1 false start data", 32'(data), 32'(hold));
        check("R1 false start ready", 32'(ready), 0);
        send(9'h081, 0, 256, 1'b1, -1, 0); verify("R1 recovery", 9'h081, 0, 0, 0);

        // R10: standby masks the request of a set flag
        stby = 1'b1; tk(1'b1, 1'b0);
        check("R10 irq masked", 32'(irq), 0);
        check("R10 ready kept", 32'(ready), 1);
        stby = 1'b0; tk(1'b1, 1'b0);
        check("R10 irq back", 32'(irq), 1);

        // R8: strobe in the completion cycle; set wins
        send(9'h066, 0, 256, 1'b1, -1, 1);
        check("R8 collision ready", 32'(ready), 1);
        do_read();
        check("R8 collision later clear", 32'(ready), 0);

        // R9: standby loads data but leaves ready clear
        stby = 1'b1;
        send(9'h1F0, 1, 256, 1'b1, -1, 0); verify("R9 standby", 9'h1F0, 1, 0, 0);
        stby = 1'b0; tk(1'b1, 1'b0);
        check("R9 ready after standby", 32'(ready), 0);

        // Random frames
        for (int k = 0; k < 24; k++) begin
            logic [8:0] d  = 9'($urandom);
            bit         n9 = bit'($urandom % 2);
            int         ps = $urandom % 3;
            int         p  = (ps == 0) ? 248 : (ps == 1) ? 256 : 264;
            logic       sv = ($urandom % 6) != 0;
            int         nbk = n9 ? 9 : 8;
            int         fl = (($urandom % 3) == 0) ? 16 * ($urandom % (nbk + 2)) + 8 : -1;
            stby = ($urandom % 4) == 0;
            if ($urandom % 2) do_read();
            send(d, n9, p, sv, fl, 0);
            verify(stby ? "R9 random" : "R3 R4 R5 random", d, n9, !sv, fl >= 0);
            stby = 1'b0;
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule